// File: doc/BRIEF.md
# External Bus Beat Sequencer with Dynamic Port Sizing

This block turns one internal access into the beats that appear on the external bus. The internal side issues a byte address, an access size (byte, half-word or word) and an optional four-word burst. It also passes in the attributes of the bank that the address decoder selected: the port width of the device, the programmed wait-state count and a burst-inhibit flag. The sequencer drives the address, the byte-lane enables and the write data for each beat. It holds each beat for its wait states and splits any access that is wider than the port into consecutive port-width beats. It collects read bytes from the correct lanes and reports completion with a one-cycle pulse.

The external data bus is numbered big-endian: lane 0 is data lines 0 to 7 and sits in bits 31:24. A narrow device is wired to the low-numbered lines. On the internal side, data is held as it would appear on a 32-bit port, so a byte at offset o within its word occupies lane o. A burst is carried as a real burst only when the bank is 32 bits wide and burst is allowed. In every other case the sequencer runs the burst as a string of single cycles.

Top module: `xbus_cycle_seq`

## Requirements
- R1: After reset `ready` is 1 and `ext_cyc` and `done` are 0. A request is taken only when `ready` is 1, and `req_valid` raised while an access is in progress has no effect on that access and starts nothing afterwards.
- R2: With `bank_port` = 0 (8-bit device), every beat enables only lane 0 (`ext_be` = 4'b0001, data bits 31:24). A half-word takes two beats and a word four beats, at addresses rising by 1.
- R3: With `bank_port` = 1 (16-bit device), an even byte uses lane 0, an odd byte uses lane 1 and a half-word uses lanes 0 and 1 (`ext_be` bit i = lane i). A word takes two beats, at the address and at the address plus 2.
- R4: With `bank_port` = 2 or 3 (32-bit device), a byte at offset o enables lane o only, a half-word at offset 0 or 2 enables lanes 0-1 or 2-3, and a word enables all four lanes in one beat.
- R5: Each beat lasts exactly 1 + `bank_wait` cycles. Address, lanes and direction are held for the whole beat, and `ext_ta` is high on its last cycle only. The first cycle of an access always carries `ext_start`.
- R6: A burst (`req_burst` = 1, always word size) on a 32-bit bank with `bank_binh` = 0 runs as four beats at addresses rising by 4. `ext_burst` is high throughout, `ext_start` appears only on the first beat, and each beat carries the full wait count.
- R7: A burst on a bank with `bank_binh` = 1, or on an 8-bit or 16-bit bank, is accepted and emulated. Each beat is a separate single cycle with its own `ext_start` and `ext_burst` low, and each word is split as in R2 and R3.
- R8: For reads, `rd_data` holds word k of the access in bits 32k+31:32k. The byte at internal offset o of a word sits in bits 31-8o:24-8o, bytes outside the access read as 0, and lanes the port does not wire are ignored.
- R9: For writes, the device receives exactly the bytes of the access at their byte addresses, taken from `req_wdata` in the same layout as R8.
- R10: `done` is high for exactly one cycle, the cycle after the last `ext_ta`. `ready` is high again in the following cycle.
- R11: Address bits below the access size are ignored (a half-word clears bit 0, a word or burst clears bits 1:0). `req_size` = 3 behaves as a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when ready |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_burst | input | 1 | Four-word burst request |
| req_wdata | input | 32*BURST_WORDS | Write data, word k in bits 32k+31:32k |
| bank_port | input | 2 | Port width: 0 8-bit, 1 16-bit, 2 or 3 32-bit |
| bank_wait | input | WAIT_W | Wait states per beat |
| bank_binh | input | 1 | Burst inhibited on this bank |
| ready | output | 1 | Idle, may take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32*BURST_WORDS | Assembled read data |
| ext_cyc | output | 1 | External beat in progress |
| ext_start | output | 1 | First cycle of an external transfer |
| ext_burst | output | 1 | Native burst in progress |
| ext_we | output | 1 | Beat direction is write |
| ext_ta | output | 1 | Last cycle of a beat, data taken |
| ext_addr | output | AW | Beat address |
| ext_be | output | 4 | Byte-lane enables, bit i = lane i |
| ext_wdata | output | 32 | Write data lanes, lane 0 in bits 31:24 |
| ext_rdata | input | 32 | Read data lanes from the device |

## Verification
On every cycle, the checker confirms that the lane enables are legal for the latched port width and that a beat holds its address, lanes and direction until its acknowledge. It also confirms that each beat's length matches the wait count through a counter of its own, that a native burst only appears on a 32-bit bank that allows bursts, and that emulated beats each start anew. The bench scenarios are needed to show which bytes end up where. They cover the split-beat address sequences, the lane chosen for each offset, read assembly with unwired lanes driven to junk, and the bytes a write leaves in the memory stub. They also confirm that `req_valid` during a busy access has no effect.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_HALF = 2'd1,
        XS_WORD = 2'd2,
        XS_WIDE = 2'd3
    } xbs_size_e;

    typedef enum logic [1:0] {
        XP_8   = 2'd0,
        XP_16  = 2'd1,
        XP_32  = 2'd2,
        XP_32B = 2'd3
    } xbs_port_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } xbs_state_e;

    // latched access attributes for the whole operation
    typedef struct packed {
        xbs_size_e size;
        logic      wr;
        logic      burst;
        xbs_port_e port;
        logic      binh;
    } xbs_ctl_t;

    function automatic logic [1:0] size_log2(input xbs_size_e s);
        case (s)
            XS_BYTE: return 2'd0;
            XS_HALF: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [1:0] port_log2(input xbs_port_e p);
        case (p)
            XP_8:    return 2'd0;
            XP_16:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // enables for 2**chunk_log lanes starting at lane_off
    function automatic logic [3:0] lane_mask(input logic [1:0] lane_off,
                                             input logic [1:0] chunk_log);
        logic [3:0] m;
        case (chunk_log)
            2'd0:    m = 4'b0001;
            2'd1:    m = 4'b0011;
            default: m = 4'b1111;
        endcase
        return m << lane_off;
    endfunction

    // big-endian byte pick: index 0 is bits 31:24
    function automatic logic [7:0] lane_byte(input logic [31:0] w,
                                             input logic [1:0] idx);
        return w[8*(3-idx) +: 8];
    endfunction

endpackage

// File: rtl/xbs_beat_plan.sv
module xbs_beat_plan
    import xbs_pkg::*;
#(
    parameter int AW     = 16,
    parameter int WIDX_W = 2
) (
    input  xbs_ctl_t          ctl,
    input  logic [AW-1:0]     base_addr,
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [1:0]        sub_idx,
    output logic [AW-1:0]     beat_addr,
    output logic [3:0]        beat_be,
    output logic [1:0]        lane_base,
    output logic              sub_last,
    output logic              native
);
    logic [1:0]    sl;
    logic [1:0]    pl;
    logic [1:0]    chunk_log;
    logic [1:0]    split_log;
    logic [1:0]    sub_max;
    logic [1:0]    pmask;
    logic [1:0]    lane_off;
    logic [AW-1:0] word_add;
    logic [AW-1:0] sub_add;

    always_comb begin
        sl        = size_log2(ctl.size);
        pl        = port_log2(ctl.port);
        chunk_log = (sl < pl) ? sl : pl;
        split_log = (sl > pl) ? (sl - pl) : 2'd0;
        case (split_log)
            2'd0:    sub_max = 2'd0;
            2'd1:    sub_max = 2'd1;
            default: sub_max = 2'd3;
        endcase
        case (pl)
            2'd0:    pmask = 2'b00;
            2'd1:    pmask = 2'b01;
            default: pmask = 2'b11;
        endcase
        word_add  = AW'(word_idx) << 2;
        sub_add   = AW'(sub_idx) << chunk_log;
        beat_addr = base_addr + word_add + sub_add;
        lane_off  = beat_addr[1:0] & pmask;
        lane_base = beat_addr[1:0] & ~pmask;
        beat_be   = lane_mask(lane_off, chunk_log);
        sub_last  = (sub_idx == sub_max);
        native    = ctl.burst && (pl == 2'd2) && !ctl.binh;
    end
endmodule

// File: rtl/xbs_lane_steer.sv
module xbs_lane_steer
    import xbs_pkg::*;
(
    input  logic [3:0]  be,
    input  logic [1:0]  lane_base,
    input  logic [31:0] wr_word,
    input  logic [31:0] ext_rd,
    input  logic [31:0] acc_word,
    output logic [31:0] ext_wr,
    output logic [31:0] merged
);
    // write side: external lane l carries internal byte lane_base + l
    for (genvar l = 0; l < 4; l++) begin : g_wr
        logic [1:0] src_off;
        assign src_off = lane_base + 2'(l);
        assign ext_wr[8*(3-l) +: 8] = be[l] ? lane_byte(wr_word, src_off) : 8'h00;
    end

    // read side: internal byte k comes from external lane k - lane_base
    for (genvar k = 0; k < 4; k++) begin : g_rd
        logic [1:0] src_lane;
        logic       take;
        assign src_lane = 2'(k) - lane_base;
        assign take     = (2'(k) >= lane_base) && be[src_lane];
        assign merged[8*(3-k) +: 8] = take ? lane_byte(ext_rd, src_lane)
                                           : acc_word[8*(3-k) +: 8];
    end
endmodule

// File: rtl/xbs_wait_timer.sv
module xbs_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [WAIT_W-1:0] wait_val,
    output logic              first,
    output logic              last
);
    logic [WAIT_W-1:0] cnt_q;

    assign first = run && (cnt_q == '0);
    assign last  = run && (cnt_q == wait_val);

    always_ff @(posedge clk) begin
        if (rst || !run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbs_pkg::*;
#(
    parameter int AW          = 16,
    parameter int WAIT_W      = 4,
    parameter int BURST_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [AW-1:0]            req_addr,
    input  logic [1:0]               req_size,
    input  logic                     req_write,
    input  logic                     req_burst,
    input  logic [32*BURST_WORDS-1:0] req_wdata,
    input  logic [1:0]               bank_port,
    input  logic [WAIT_W-1:0]        bank_wait,
    input  logic                     bank_binh,
    output logic                     ready,
    output logic                     done,
    output logic [32*BURST_WORDS-1:0] rd_data,
    output logic                     ext_cyc,
    output logic                     ext_start,
    output logic                     ext_burst,
    output logic                     ext_we,
    output logic                     ext_ta,
    output logic [AW-1:0]            ext_addr,
    output logic [3:0]               ext_be,
    output logic [31:0]              ext_wdata,
    input  logic [31:0]              ext_rdata
);
    localparam int WIDX_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

    xbs_state_e                   state_q;
    xbs_ctl_t                     ctl_q;
    logic [AW-1:0]                base_q;
    logic [WAIT_W-1:0]            wait_q;
    logic [BURST_WORDS-1:0][31:0] wbuf_q;
    logic [BURST_WORDS-1:0][31:0] rbuf_q;
    logic [WIDX_W-1:0]            word_q;
    logic [1:0]                   sub_q;

    logic          accept;
    logic          run;
    logic          tmr_first;
    logic          tmr_last;
    logic          sub_last;
    logic          native;
    logic          word_last;
    logic [AW-1:0] beat_addr;
    logic [3:0]    beat_be;
    logic [1:0]    lane_base;
    logic [31:0]   wr_lanes;
    logic [31:0]   rd_merged;
    xbs_size_e     size_eff;
    logic [AW-1:0] acc_base;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign run       = (state_q == ST_RUN);
    assign word_last = !ctl_q.burst || (word_q == WIDX_W'(BURST_WORDS-1));

    // size and alignment of an incoming request
    always_comb begin
        size_eff = req_burst ? XS_WORD : xbs_size_e'(req_size);
        acc_base = req_addr;
        case (size_log2(size_eff))
            2'd0:    acc_base = req_addr;
            2'd1:    acc_base[0] = 1'b0;
            default: acc_base[1:0] = 2'b00;
        endcase
    end

    xbs_beat_plan #(.AW(AW), .WIDX_W(WIDX_W)) u_plan (
        .ctl       (ctl_q),
        .base_addr (base_q),
        .word_idx  (word_q),
        .sub_idx   (sub_q),
        .beat_addr (beat_addr),
        .beat_be   (beat_be),
        .lane_base (lane_base),
        .sub_last  (sub_last),
        .native    (native)
    );

    xbs_lane_steer u_steer (
        .be        (beat_be),
        .lane_base (lane_base),
        .wr_word   (wbuf_q[word_q]),
        .ext_rd    (ext_rdata),
        .acc_word  (rbuf_q[word_q]),
        .ext_wr    (wr_lanes),
        .merged    (rd_merged)
    );

    xbs_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wait_val (wait_q),
        .first    (tmr_first),
        .last     (tmr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            base_q  <= '0;
            wait_q  <= '0;
            wbuf_q  <= '0;
            rbuf_q  <= '0;
            word_q  <= '0;
            sub_q   <= 2'd0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        ctl_q   <= '{size: size_eff, wr: req_write, burst: req_burst,
                                     port: xbs_port_e'(bank_port), binh: bank_binh};
                        base_q  <= acc_base;
                        wait_q  <= bank_wait;
                        wbuf_q  <= req_wdata;
                        rbuf_q  <= '0;
                        word_q  <= '0;
                        sub_q   <= 2'd0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tmr_last) begin
                        if (!ctl_q.wr) begin
                            rbuf_q[word_q] <= rd_merged;
                        end
                        if (sub_last) begin
                            sub_q <= 2'd0;
                            if (word_last) begin
                                state_q <= ST_FIN;
                            end else begin
                                word_q <= word_q + 1'b1;
                            end
                        end else begin
                            sub_q <= sub_q + 2'd1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready     = (state_q == ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign rd_data   = rbuf_q;
    assign ext_cyc   = run;
    assign ext_start = run && tmr_first && (!native || ((word_q == '0) && (sub_q == 2'd0)));
    assign ext_burst = run && native;
    assign ext_we    = run && ctl_q.wr;
    assign ext_ta    = tmr_last;
    assign ext_addr  = run ? beat_addr : '0;
    assign ext_be    = run ? beat_be : 4'b0000;
    assign ext_wdata = (run && ctl_q.wr) ? wr_lanes : 32'h0;
endmodule

// File: rtl/xbs_seq_chk.sv
module xbs_seq_chk
    import xbs_pkg::*;
#(
    parameter int AW     = 16,
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              done,
    input logic              ext_cyc,
    input logic              ext_start,
    input logic              ext_burst,
    input logic              ext_we,
    input logic              ext_ta,
    input logic [AW-1:0]     ext_addr,
    input logic [3:0]        ext_be,
    input xbs_port_e         port_q,
    input logic              binh_q,
    input logic [WAIT_W-1:0] wait_q
);
    // independent count of cycles spent in the current beat
    logic [WAIT_W-1:0] beat_cnt;
    always_ff @(posedge clk) begin
        if (rst || !ext_cyc || ext_ta) beat_cnt <= '0;
        else                           beat_cnt <= beat_cnt + 1'b1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!ext_cyc && !done));

    p_lane8_r2: assert property (@(posedge clk) disable iff (rst)
        (ext_cyc && port_q == XP_8) |-> (ext_be == 4'b0001));

    p_lane16_r3: assert property (@(posedge clk) disable iff (rst)
        (ext_cyc && port_q == XP_16) |-> (ext_be[3:2] == 2'b00 && ext_be != 4'b0000));

    p_lane_legal_r4: assert property (@(posedge clk) disable iff (rst)
        ext_cyc |-> (ext_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                    4'b0011, 4'b1100, 4'b1111}));

    p_beat_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (ext_cyc && !ext_ta) |=> (ext_cyc && $stable(ext_addr) && $stable(ext_be) && $stable(ext_we)));

    p_wait_len_r5: assert property (@(posedge clk) disable iff (rst)
        ext_ta |-> (beat_cnt == wait_q));

    p_first_start_r5: assert property (@(posedge clk) disable iff (rst)
        (ext_cyc && !$past(ext_cyc)) |-> ext_start);

    p_native_ok_r6: assert property (@(posedge clk) disable iff (rst)
        ext_burst |-> ((port_q == XP_32 || port_q == XP_32B) && !binh_q));

    p_emul_start_r7: assert property (@(posedge clk) disable iff (rst)
        (ext_cyc && !ext_burst && $past(ext_ta)) |-> ext_start);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && ready));

    p_done_after_ta_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ext_ta));
endmodule

bind xbus_cycle_seq xbs_seq_chk #(.AW(AW), .WAIT_W(WAIT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .done      (done),
    .ext_cyc   (ext_cyc),
    .ext_start (ext_start),
    .ext_burst (ext_burst),
    .ext_we    (ext_we),
    .ext_ta    (ext_ta),
    .ext_addr  (ext_addr),
    .ext_be    (ext_be),
    .port_q    (ctl_q.port),
    .binh_q    (ctl_q.binh),
    .wait_q    (wait_q)
);

// File: tb/sim_xbus_cycle_seq.sv
`timescale 1ns/1ps
module sim_xbus_cycle_seq;
    localparam int AW = 16;
    localparam int WW = 4;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic          req_burst = 1'b0;
    logic [127:0]  req_wdata = '0;
    logic [1:0]    bank_port = '0;
    logic [WW-1:0] bank_wait = '0;
    logic          bank_binh = 1'b0;
    logic          ready, done;
    logic [127:0]  rd_data;
    logic          ext_cyc, ext_start, ext_burst, ext_we, ext_ta;
    logic [AW-1:0] ext_addr;
    logic [3:0]    ext_be;
    logic [31:0]   ext_wdata;
    logic [31:0]   ext_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cur_port = 2;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    always #5 clk = ~clk;

    xbus_cycle_seq #(.AW(AW), .WAIT_W(WW), .BURST_WORDS(BW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_burst(req_burst),
        .req_wdata(req_wdata), .bank_port(bank_port), .bank_wait(bank_wait),
        .bank_binh(bank_binh), .ready(ready), .done(done), .rd_data(rd_data),
        .ext_cyc(ext_cyc), .ext_start(ext_start), .ext_burst(ext_burst),
        .ext_we(ext_we), .ext_ta(ext_ta), .ext_addr(ext_addr), .ext_be(ext_be),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    function automatic int pbytes(input int pt);
        return (pt == 0) ? 1 : (pt == 1) ? 2 : 4;
    endfunction

    // memory stub: device wired to the low-numbered lanes, others float to junk
    always_comb begin
        int p;
        p = pbytes(cur_port);
        ext_rdata = 32'hEEEE_EEEE;
        for (int l = 0; l < 4; l++) begin
            if (l < p) ext_rdata[8*(3-l) +: 8] = mem[((int'(ext_addr) & ~(p-1)) + l) & 255];
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
        end else if (ext_ta && ext_we) begin
            for (int l = 0; l < 4; l++) begin
                if (ext_be[l])
                    mem[((int'(ext_addr) & ~(pbytes(cur_port)-1)) + l) & 255] <= ext_wdata[8*(3-l) +: 8];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run_op(input logic [15:0] a, input int sz, input bit wr, input bit bu,
                          input int pt, input int wt, input bit bi,
                          input logic [127:0] wd, input bit poke, input string tag);
        int sl, pl, cl, words, split, nbeats, p, cyc, st, bc, nta, guard;
        bit nat;
        logic [15:0] base;
        logic [15:0] exp_a [16];
        logic [3:0]  exp_be [16];
        logic [15:0] seen_a [16];
        logic [3:0]  seen_be [16];
        logic [127:0] exp_rd;
        bit lanes_ok;
        int esz;
        esz   = bu ? 2 : ((sz == 3) ? 2 : sz);
        sl    = esz;
        pl    = (pt == 0) ? 0 : (pt == 1) ? 1 : 2;
        p     = 1 << pl;
        cl    = (sl < pl) ? sl : pl;
        words = bu ? BW : 1;
        split = (sl > pl) ? (1 << (sl - pl)) : 1;
        nbeats = words * split;
        nat   = bu && (pl == 2) && !bi;
        base  = a & ~16'((1 << sl) - 1);
        // expected beats
        for (int w = 0; w < words; w++) begin
            for (int s = 0; s < split; s++) begin
                exp_a[w*split+s]  = base + 16'(4*w) + 16'(s * (1 << cl));
                exp_be[w*split+s] = 4'((((1 << (1 << cl)) - 1) << (int'(exp_a[w*split+s]) % p)) & 15);
            end
        end
        // expected read data and memory image
        exp_rd = '0;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        for (int w = 0; w < words; w++) begin
            for (int o = 0; o < 4; o++) begin
                int lo;
                int idx;
                lo  = int'(base[1:0]);
                idx = ((int'(base) & ~3) + 4*w + o) & 255;
                if (o >= lo && o < lo + (1 << sl)) begin
                    exp_rd[32*w + 8*(3-o) +: 8] = mem[idx];
                    if (wr) exp_mem[idx] = wd[32*w + 8*(3-o) +: 8];
                end
            end
        end
        // issue
        while (!ready) @(negedge clk);
        cur_port  = pt;
        req_addr  = a;
        req_size  = 2'(sz);
        req_write = wr;
        req_burst = bu;
        req_wdata = wd;
        bank_port = 2'(pt);
        bank_wait = WW'(wt);
        bank_binh = bi;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; st = 0; bc = 0; nta = 0; guard = 0;
        while (!done && guard < 2000) begin
            if (ext_cyc) cyc++;
            if (ext_start) st++;
            if (ext_burst) bc++;
            if (ext_ta && nta < 16) begin
                seen_a[nta]  = ext_addr;
                seen_be[nta] = ext_be;
                nta++;
            end
            if (poke && guard == 1) begin
                req_valid = 1'b1;
                req_addr  = ~a;
                req_write = ~wr;
                req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(done == 1'b1, {tag, " R10 done seen"}, 128'(done), 128'd1);
        // R5 beat timing
        chk(cyc == nbeats * (1 + wt), {tag, " R5 cycles"}, 128'(cyc), 128'(nbeats * (1 + wt)));
        // R2/R3/R4 beat addresses and lanes
        lanes_ok = (nta == nbeats);
        for (int k = 0; k < nbeats && k < 16; k++) begin
            if (seen_a[k] !== exp_a[k] || seen_be[k] !== exp_be[k]) lanes_ok = 0;
        end
        chk(lanes_ok, {tag, (pl == 0) ? " R2 beats" : (pl == 1) ? " R3 beats" : " R4 beats"},
            {seen_a[0], 12'h0, seen_be[0], 96'(nta)}, {exp_a[0], 12'h0, exp_be[0], 96'(nbeats)});
        // R6/R7 start and burst strobes
        chk(st == (nat ? 1 : nbeats) && bc == (nat ? cyc : 0),
            {tag, nat ? " R6 native burst" : " R7 single starts"},
            {64'(st), 64'(bc)}, {64'(nat ? 1 : nbeats), 64'(nat ? cyc : 0)});
        if (wr) begin
            bit same;
            same = 1;
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) same = 0;
            chk(same, {tag, " R9 memory image"}, 128'(same), 128'd1);
        end else begin
            chk(rd_data === exp_rd, {tag, " R8 read data"}, rd_data, exp_rd);
        end
        @(negedge clk);
        chk(!done && ready, {tag, " R10 single pulse then ready"}, {126'd0, done, ready}, 128'd1);
        if (poke) begin
            bit quiet;
            quiet = 1;
            for (int i = 0; i < 3; i++) begin
                if (ext_cyc) quiet = 0;
                @(negedge clk);
            end
            chk(quiet, {tag, " R1 busy request ignored"}, 128'(quiet), 128'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(ready && !ext_cyc && !done, "R1 reset state", {125'd0, ready, ext_cyc, done}, 128'd4);
        rst = 1'b0;
        @(negedge clk);
        chk(ready && !ext_cyc && !done, "R1 idle after reset", {125'd0, ready, ext_cyc, done}, 128'd4);

        // directed corners
        run_op(16'h0020, 2, 0, 0, 0, 2, 0, '0, 0, "word on 8-bit");
        run_op(16'h0031, 1, 1, 0, 0, 0, 0, 128'hA5B6, 0, "half on 8-bit");
        run_op(16'h0013, 1, 0, 0, 1, 1, 0, '0, 0, "R11 odd half on 16-bit");
        run_op(16'h0045, 0, 1, 0, 1, 0, 0, 128'h00CC_0000, 0, "odd byte on 16-bit");
        run_op(16'h0046, 3, 0, 0, 1, 3, 0, '0, 0, "R11 size3 word on 16-bit");
        run_op(16'h0052, 1, 1, 0, 2, 0, 0, 128'h0000_1234, 0, "half offset2 on 32-bit");
        run_op(16'h0063, 0, 0, 0, 2, 1, 0, '0, 0, "byte offset3 on 32-bit");
        run_op(16'h0071, 2, 0, 0, 3, 15, 0, '0, 0, "R11 word max wait");
        run_op(16'h0080, 2, 0, 1, 2, 1, 0, '0, 0, "native burst read");
        run_op(16'h0090, 2, 1, 1, 2, 2, 0, {32'h11223344, 32'h55667788, 32'h99AABBCC, 32'hDDEEFF00}, 0, "native burst write");
        run_op(16'h00A0, 2, 0, 1, 2, 0, 1, '0, 0, "inhibited burst");
        run_op(16'h00B0, 0, 1, 1, 1, 1, 0, {4{32'hCAFE_F00D}}, 0, "burst on 16-bit");
        run_op(16'h00C0, 2, 0, 1, 0, 0, 0, '0, 1, "burst on 8-bit busy poke");

        for (int n = 0; n < 70; n++) begin
            logic [15:0] a;
            logic [127:0] wd;
            a  = 16'($urandom & 32'hFF);
            wd = {$urandom, $urandom, $urandom, $urandom};
            run_op(a, int'($urandom % 4), bit'($urandom % 2), ($urandom % 4) == 0,
                   int'($urandom % 4), int'($urandom % 4), bit'($urandom % 2), wd,
                   ($urandom % 5) == 0, "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule